// File: doc/BRIEF.md
# PHY Event Interrupt Controller

This block is the interrupt unit on the management side of an Ethernet PHY. Seven event sources feed it. Four of them arrive as single-cycle pulses: energy detect, auto-negotiation complete, false-carrier counter half-full and receive-error counter half-full. Three arrive as levels: link, speed and duplex. The block turns each change of a level into a pulse of its own. Every event is latched into a pending bit. A pending bit is set whether or not that event is enabled, and all pending bits clear together when software reads the status register.

The pending bits are combined with per-event enables and a global enable to form one interrupt. A test bit forces the interrupt regardless of events. The interrupt leaves the block on an active-low pin, and a control bit decides whether that pin is driven as an interrupt output at all.

Software sees two 16-bit registers through a read strobe, a write strobe and a one-bit register select. Read data is combinational from the current state. A read or a write takes effect at the clock edge on which its strobe is high.

Top module: `phy_irq_ctrl`

## Requirements
- R1: After reset every pending bit, every enable bit and every control bit is 0. The status and control registers read 0x0000, `irq_oe` is 0 and `irq_n` is 1.
- R2: An event sampled high at a clock edge sets its pending bit at that edge, whether or not its enable is set. The pending bits sit in status register bits 14..8: energy detect at 14, link change at 13, speed change at 12, duplex change at 11, auto-negotiation complete at 10, false-carrier half-full at 9 and receive-error half-full at 8.
- R3: Any change of `lvl_link`, `lvl_speed` or `lvl_duplex`, rising or falling, between two clock edges counts as that event. The previous value follows the input during reset, so a level held steady across the release of reset raises no event.
- R4: A status read (`reg_sel`=1, `reg_rd`=1) returns the pending bits held before the edge and clears them all at that edge. Without a read, pending bits hold their value.
- R5: An event at the same edge as a status read is not shown in that read's data, and its pending bit is set after the edge.
- R6: Writing the status register loads only the enable bits 6..0. These are in the same event order as the pending bits. Status bits 15 and 7 always read 0. The control register (`reg_sel`=0) holds output enable at bit 0, global enable at bit 1 and test at bit 2. Control bits 15..3 read 0.
- R7: When the test bit is clear, the interrupt is active exactly when the global enable is set and at least one pending bit has its enable set.
- R8: While the test bit is set, the interrupt is active whatever the events, pending bits and enables are.
- R9: `irq_oe` equals control bit 0. While it is 1, `irq_n` is the inverse of the interrupt. While it is 0, `irq_n` stays at 1.
- R10: Reading the control register leaves the pending bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 control, 1 status/enable |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears pending on a status read) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| ev_energy | input | 1 | Energy detect pulse |
| ev_an_done | input | 1 | Auto-negotiation complete pulse |
| ev_fc_half | input | 1 | False-carrier counter half-full pulse |
| ev_rxerr_half | input | 1 | Receive-error counter half-full pulse |
| lvl_link | input | 1 | Link status level |
| lvl_speed | input | 1 | Speed status level |
| lvl_duplex | input | 1 | Duplex status level |
| irq_n | output | 1 | Active-low interrupt pin value |
| irq_oe | output | 1 | Pin is driven as an interrupt output |

## Verification
The hardest case to bring about from the ports is an event that lands at the very edge of a status read. The old value must be returned, and the new bit must survive the clear. The bench raises the read strobe and an event pulse in the same cycle. It checks the read data before the edge and the pin and the next read after it. The sweep covers every enable mask against every single event, toggling the level inputs alternately in both directions. A level held high across the release of reset checks that no event is raised at start-up.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int REG_W    = 16;
  localparam int EVT_N    = 7;
  localparam int LVL_N    = 3;
  localparam int PEND_LSB = 8;
  localparam int EN_LSB   = 0;
  localparam int CTL_OE   = 0;
  localparam int CTL_GEN  = 1;
  localparam int CTL_TEST = 2;
  localparam int CTL_N    = 3;
  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_STAT = 1'b1;

  // Status view: pending bits above, enable bits below, gaps read zero.
  function automatic logic [REG_W-1:0] pack_status(input logic [EVT_N-1:0] pend,
                                                   input logic [EVT_N-1:0] en);
    logic [REG_W-1:0] v;
    v = '0;
    v[PEND_LSB +: EVT_N] = pend;
    v[EN_LSB +: EVT_N]   = en;
    return v;
  endfunction

  function automatic logic irq_level(input logic test, input logic gen,
                                     input logic [EVT_N-1:0] pend,
                                     input logic [EVT_N-1:0] en);
    return test | (gen & (|(pend & en)));
  endfunction
endpackage

// File: rtl/irq_change_detect.sv
module irq_change_detect #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] chg
);
  logic [W-1:0] prev;

  // The previous value tracks the input during reset too, so a level that is
  // steady across reset release raises no change.
  always_ff @(posedge clk) prev <= lvl;

  assign chg = lvl ^ prev;

  a_r3_change_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != $past(lvl)) |-> (chg == (lvl ^ $past(lvl))));
endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (clr ? '0 : pend) | evt;
  end

  a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((pend & $past(evt)) == $past(evt)));
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt == '0) |=> (pend == '0));
  a_r4_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && evt == '0) |=> $stable(pend));
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import phy_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  output logic [EVT_N-1:0] en,
  output logic [CTL_N-1:0] ctl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en  <= '0;
      ctl <= '0;
    end else if (wr) begin
      if (sel == SEL_STAT) en  <= wdata[EN_LSB +: EVT_N];
      else                 ctl <= wdata[CTL_N-1:0];
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (en == '0 && ctl == '0));
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
  import phy_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ev_energy,
  input  logic             ev_an_done,
  input  logic             ev_fc_half,
  input  logic             ev_rxerr_half,
  input  logic             lvl_link,
  input  logic             lvl_speed,
  input  logic             lvl_duplex,
  output logic             irq_n,
  output logic             irq_oe
);
  logic [LVL_N-1:0] lvl_chg;
  logic [EVT_N-1:0] evt_all;
  logic [EVT_N-1:0] pend;
  logic [EVT_N-1:0] en;
  logic [CTL_N-1:0] ctl;
  logic             stat_read;
  logic             irq_act;

  irq_change_detect #(.W(LVL_N)) u_chg (
    .clk(clk), .rst_n(rst_n),
    .lvl({lvl_link, lvl_speed, lvl_duplex}),
    .chg(lvl_chg)
  );

  // Event order, top to bottom: energy, link, speed, duplex, an_done, fc, rxerr.
  assign evt_all   = {ev_energy, lvl_chg, ev_an_done, ev_fc_half, ev_rxerr_half};
  assign stat_read = reg_rd && (reg_sel == SEL_STAT);

  irq_pending_bank #(.N(EVT_N)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(evt_all), .clr(stat_read), .pend(pend)
  );

  irq_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .en(en), .ctl(ctl)
  );

  always_comb begin
    if (reg_sel == SEL_STAT) reg_rdata = pack_status(pend, en);
    else                     reg_rdata = {{(REG_W-CTL_N){1'b0}}, ctl};
  end

  assign irq_act = irq_level(ctl[CTL_TEST], ctl[CTL_GEN], pend, en);
  assign irq_oe  = ctl[CTL_OE];
  assign irq_n   = ctl[CTL_OE] ? ~irq_act : 1'b1;

  a_r8_test_forces: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[CTL_TEST] |-> irq_act);
  a_r7_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[CTL_TEST] && !ctl[CTL_GEN]) |-> !irq_act);
  a_r9_pin_released: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_oe |-> irq_n);
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[15] == 1'b0 && reg_rdata[7] == 1'b0));
  a_r10_ctrl_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == SEL_CTRL && evt_all == '0) |=> $stable(pend));
endmodule

// File: tb/phy_irq_ctrl_test.sv
module phy_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ev_energy = 0, ev_an_done = 0, ev_fc_half = 0, ev_rxerr_half = 0;
  logic        lvl_link = 0, lvl_speed = 0, lvl_duplex = 0;
  logic        irq_n, irq_oe;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;

  phy_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_energy(ev_energy), .ev_an_done(ev_an_done), .ev_fc_half(ev_fc_half),
    .ev_rxerr_half(ev_rxerr_half), .lvl_link(lvl_link), .lvl_speed(lvl_speed),
    .lvl_duplex(lvl_duplex), .irq_n(irq_n), .irq_oe(irq_oe)
  );

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    tick; reg_wr = 1'b0;
  endtask

  // Status read: check the data before the edge, the edge then clears pending.
  task automatic rd_chk(input string tag, input logic sel, input logic [15:0] exp);
    reg_sel = sel; reg_rd = 1'b1; #1;
    chk(tag, reg_rdata, exp);
    tick; reg_rd = 1'b0;
  endtask

  // Event index 6..0: energy, link, speed, duplex, an_done, fc, rxerr.
  task automatic fire(input int e);
    case (e)
      6: ev_energy = 1'b1;
      5: lvl_link = ~lvl_link;
      4: lvl_speed = ~lvl_speed;
      3: lvl_duplex = ~lvl_duplex;
      2: ev_an_done = 1'b1;
      1: ev_fc_half = 1'b1;
      default: ev_rxerr_half = 1'b1;
    endcase
  endtask

  task automatic quiet;
    ev_energy = 0; ev_an_done = 0; ev_fc_half = 0; ev_rxerr_half = 0;
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    lvl_link = 1'b1;               // held high across reset release (R3)
    repeat (3) tick;
    rst_n = 1'b1;
    tick; #1;
    chk("R1 irq_n", {15'd0, irq_n}, 16'd1);
    chk("R1 irq_oe", {15'd0, irq_oe}, 16'd0);
    rd_chk("R1 ctrl", 1'b0, 16'h0000);
    rd_chk("R1 R3 status no start-up event", 1'b1, 16'h0000);

    // Sweep: every enable mask against every single event (R2 R3 R4 R7 R9).
    wr(1'b0, 16'h0003);
    for (int m = 0; m < 128; m++) begin
      wr(1'b1, 16'(m));
      for (int e = 0; e < 7; e++) begin
        fire(e); tick; quiet; #1;
        chk("R7 irq per enable", {15'd0, irq_n}, {15'd0, ~m[e]});
        rd_chk("R2 pending position", 1'b1, 16'(1 << (8 + e)) | 16'(m));
        #1;
        chk("R4 cleared by read", {15'd0, irq_n}, 16'd1);
      end
    end

    // R2 all events in one cycle, enables off.
    wr(1'b1, 16'h0000);
    for (int e = 0; e < 7; e++) fire(e);
    tick; quiet;
    rd_chk("R2 all at once", 1'b1, 16'h7F00);

    // R5 event at the same edge as a status read.
    wr(1'b1, 16'h007F);
    reg_sel = 1'b1; reg_rd = 1'b1; ev_an_done = 1'b1; #1;
    chk("R5 read shows old", reg_rdata, 16'h007F);
    tick; reg_rd = 1'b0; quiet; #1;
    chk("R5 irq after collision", {15'd0, irq_n}, 16'd0);
    rd_chk("R5 bit kept", 1'b1, 16'h047F);

    // R10 control read keeps pending.
    fire(6); tick; quiet;
    rd_chk("R10 ctrl read", 1'b0, 16'h0003);
    rd_chk("R10 pending kept", 1'b1, 16'h407F);

    // R6 reserved and read-only fields.
    wr(1'b1, 16'hFFFF);
    rd_chk("R6 status write", 1'b1, 16'h007F);
    wr(1'b0, 16'hFFF8);
    rd_chk("R6 ctrl reserved", 1'b0, 16'h0000);

    // R7 global enable gates the pin; pending kept meanwhile.
    wr(1'b0, 16'h0001);
    fire(1); tick; quiet; #1;
    chk("R7 global off", {15'd0, irq_n}, 16'd1);
    wr(1'b0, 16'h0003); #1;
    chk("R7 global on", {15'd0, irq_n}, 16'd0);
    rd_chk("R7 pending", 1'b1, 16'h027F);

    // R8 test forces; R9 output enable.
    wr(1'b1, 16'h0000);
    wr(1'b0, 16'h0005); #1;
    chk("R8 test forces", {15'd0, irq_n}, 16'd0);
    wr(1'b0, 16'h0004); #1;
    chk("R9 pin released", {15'd0, irq_n}, 16'd1);
    chk("R9 oe low", {15'd0, irq_oe}, 16'd0);
    rd_chk("R6 ctrl readback", 1'b0, 16'h0004);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule